// File: doc/BRIEF.md
# ROM Traffic Light Sequencer

This block runs the lights of a two-way crossing as a state machine whose next-state and lamp logic is a constant lookup table instead of a gate network. On every clock the table is read at the address formed by the current phase code with the east-west car sensor appended as the lowest bit. The word it returns carries the following phase code and the lamp pattern for the current phase. The phase code goes into the phase register and the lamp pattern into the light register. The lights therefore show the pattern of the phase the machine has just left.

The phase cycle works as follows. North-south green lasts at least three phases. The third green phase waits for an east-west car. A single yellow phase follows, then a single all-red phase. East-west green then holds for as long as the sensor stays high, and is followed by one yellow phase and one all-red phase before north-south green begins again. A synchronous reset returns the machine to the first north-south green phase.

Top module: `tl_rom_seq`

## Requirements
- R1: `lights[5:3]` is the north-south group and `lights[2:0]` the east-west group. Each group is one-hot, with green = 100, yellow = 010 and red = 001.
- R2: While `rst` is high at a rising edge, the phase goes to the first north-south green phase (code 000) and `lights` loads 100001.
- R3: From the first north-south green phase, the machine takes the second and then the third green phase on the next two edges, whatever `car_ew` is. North-south green is therefore shown for at least three cycles.
- R4: In the third north-south green phase, the machine stays there while `car_ew` is low and moves to north-south yellow on the edge where `car_ew` is high.
- R5: North-south yellow lasts exactly one phase and is followed by exactly one all-red phase, then east-west green.
- R6: East-west green repeats on every edge where `car_ew` is high and moves to east-west yellow on the first edge where it is low. With the sensor high for N edges, east-west green is held N further cycles.
- R7: East-west yellow lasts exactly one phase and is followed by exactly one all-red phase, then the first north-south green phase.
- R8: `lights` is registered. Outside reset it equals, one clock later, the lamp pattern of the phase the table was addressed with: north-south green phases give 100001, north-south yellow 010001, both all-red phases 001001, east-west green 001100 and east-west yellow 001010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| car_ew | input | 1 | East-west car sensor, sampled at each edge as the table address LSB |
| lights | output | 6 | Registered lamps, north-south group in the upper three bits |

## Verification
The phase changes on the edge that samples `car_ew`, and the lamps for that phase appear one edge later. A stimulus applied before edge k therefore first shows up in `lights` after edge k+1. The bench drives `car_ew` on the falling edge and reads `lights` on the next falling edge. It compares that value with a model that registers the lamp pattern of the phase it held before the edge, so the one-cycle lag is part of the model. The reset pattern is checked after the first falling edge that follows the reset edge. The hold and all-red counts are taken from successive samples of this kind.

// File: rtl/tl_rom_pkg.sv
package tl_rom_pkg;

  localparam int PH_W      = 3;
  localparam int CAR_W     = 1;
  localparam int GRP_W     = 3;
  localparam int N_GRP     = 2;
  localparam int LAMP_W    = GRP_W * N_GRP;
  localparam int ADDR_W    = PH_W + CAR_W;
  localparam int WORD_W    = PH_W + LAMP_W;
  localparam int ROM_DEPTH = 1 << ADDR_W;

  typedef enum logic [PH_W-1:0] {
    PH_NS_GO1  = 3'd0,
    PH_NS_GO2  = 3'd1,
    PH_NS_GO3  = 3'd2,
    PH_NS_SLOW = 3'd3,
    PH_NS_STOP = 3'd4,
    PH_EW_GO   = 3'd5,
    PH_EW_SLOW = 3'd6,
    PH_EW_STOP = 3'd7
  } phase_t;

  localparam logic [GRP_W-1:0] LIT_GO   = 3'b100;
  localparam logic [GRP_W-1:0] LIT_SLOW = 3'b010;
  localparam logic [GRP_W-1:0] LIT_STOP = 3'b001;

  localparam logic [LAMP_W-1:0] LAMP_RESET = {LIT_GO, LIT_STOP};

  // Lamp pattern of a phase, derived from phase ranges, not from the table.
  function automatic logic [LAMP_W-1:0] lamps_of(phase_t p);
    logic [GRP_W-1:0] ns;
    logic [GRP_W-1:0] ew;
    ns = (p <= PH_NS_GO3) ? LIT_GO : (p == PH_NS_SLOW) ? LIT_SLOW : LIT_STOP;
    ew = (p == PH_EW_GO) ? LIT_GO : (p == PH_EW_SLOW) ? LIT_SLOW : LIT_STOP;
    return {ns, ew};
  endfunction

  // Table address: phase code above, sensor as LSB.
  function automatic logic [ADDR_W-1:0] rom_index(phase_t p, logic [CAR_W-1:0] car);
    return {p, car};
  endfunction

endpackage

// File: rtl/tl_rom_table.sv
module tl_rom_table
  import tl_rom_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word
);

  // Word layout: {next phase code, NS lamps, EW lamps}; entry index = {phase, car_ew}.
  localparam logic [WORD_W-1:0] ROM_IMG [ROM_DEPTH] = '{
    9'b001_100_001, 9'b001_100_001,   // NS go 1 -> NS go 2
    9'b010_100_001, 9'b010_100_001,   // NS go 2 -> NS go 3
    9'b010_100_001, 9'b011_100_001,   // NS go 3 : wait / to NS slow
    9'b100_010_001, 9'b100_010_001,   // NS slow -> NS stop
    9'b101_001_001, 9'b101_001_001,   // NS stop -> EW go
    9'b110_001_100, 9'b101_001_100,   // EW go : to EW slow / hold
    9'b111_001_010, 9'b111_001_010,   // EW slow -> EW stop
    9'b000_001_001, 9'b000_001_001    // EW stop -> NS go 1
  };

  assign word = ROM_IMG[addr];

endmodule

// File: rtl/tl_phase_reg.sv
module tl_phase_reg
  import tl_rom_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CAR_W-1:0]  car_ew,
  input  logic [PH_W-1:0]   ph_nxt,
  output phase_t            ph_q
);

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_NS_GO1;
    else     ph_q <= phase_t'(ph_nxt);
  end

  // Named events for the checks below.
  logic at_go1, at_go2, at_go3, at_ns_slow, at_ns_stop, at_ew_go, at_ew_slow, at_ew_stop;
  logic car_on;
  assign at_go1     = (ph_q == PH_NS_GO1);
  assign at_go2     = (ph_q == PH_NS_GO2);
  assign at_go3     = (ph_q == PH_NS_GO3);
  assign at_ns_slow = (ph_q == PH_NS_SLOW);
  assign at_ns_stop = (ph_q == PH_NS_STOP);
  assign at_ew_go   = (ph_q == PH_EW_GO);
  assign at_ew_slow = (ph_q == PH_EW_SLOW);
  assign at_ew_stop = (ph_q == PH_EW_STOP);
  assign car_on     = |car_ew;

  AST_RESET_PHASE:  assert property (@(posedge clk) rst |=> ph_q == PH_NS_GO1);                                 // R2
  AST_GO1_STEP:     assert property (@(posedge clk) disable iff (rst) at_go1 |=> ph_q == PH_NS_GO2);             // R3
  AST_GO2_STEP:     assert property (@(posedge clk) disable iff (rst) at_go2 |=> ph_q == PH_NS_GO3);             // R3
  AST_GO3_WAIT:     assert property (@(posedge clk) disable iff (rst) (at_go3 && !car_on) |=> ph_q == PH_NS_GO3); // R4
  AST_GO3_LEAVE:    assert property (@(posedge clk) disable iff (rst) (at_go3 && car_on) |=> ph_q == PH_NS_SLOW); // R4
  AST_NS_SLOW_ONCE: assert property (@(posedge clk) disable iff (rst) at_ns_slow |=> ph_q == PH_NS_STOP);         // R5
  AST_NS_STOP_ONCE: assert property (@(posedge clk) disable iff (rst) at_ns_stop |=> ph_q == PH_EW_GO);           // R5
  AST_EW_HOLD:      assert property (@(posedge clk) disable iff (rst) (at_ew_go && car_on) |=> ph_q == PH_EW_GO); // R6
  AST_EW_RELEASE:   assert property (@(posedge clk) disable iff (rst) (at_ew_go && !car_on) |=> ph_q == PH_EW_SLOW); // R6
  AST_EW_SLOW_ONCE: assert property (@(posedge clk) disable iff (rst) at_ew_slow |=> ph_q == PH_EW_STOP);         // R7
  AST_EW_STOP_ONCE: assert property (@(posedge clk) disable iff (rst) at_ew_stop |=> ph_q == PH_NS_GO1);          // R7

endmodule

// File: rtl/tl_lamp_reg.sv
module tl_lamp_reg
  import tl_rom_pkg::*;
#(
  parameter int                         G_W    = GRP_W,
  parameter int                         G_N    = N_GRP,
  parameter logic [G_W*G_N-1:0]         RST_PAT = LAMP_RESET
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [G_W*G_N-1:0] lamp_d,
  output logic [G_W*G_N-1:0] lamp_q
);

  for (genvar g = 0; g < G_N; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) lamp_q[g*G_W +: G_W] <= RST_PAT[g*G_W +: G_W];
      else     lamp_q[g*G_W +: G_W] <= lamp_d[g*G_W +: G_W];
    end

    AST_GROUP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(lamp_q[g*G_W +: G_W]) == 1);                                                  // R1
  end

  AST_RESET_LAMPS: assert property (@(posedge clk) rst |=> lamp_q == RST_PAT);                  // R2

endmodule

// File: rtl/tl_rom_seq.sv
module tl_rom_seq
  import tl_rom_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              car_ew,
  output logic [5:0]        lights
);

  phase_t              ph_q;
  logic [ADDR_W-1:0]   rom_addr;
  logic [WORD_W-1:0]   rom_word;
  logic [PH_W-1:0]     ph_nxt;
  logic [LAMP_W-1:0]   lamp_d;
  logic [LAMP_W-1:0]   lamp_q;

  assign rom_addr = rom_index(ph_q, car_ew);

  tl_rom_table u_table (
    .addr (rom_addr),
    .word (rom_word)
  );

  assign ph_nxt = rom_word[WORD_W-1 -: PH_W];
  assign lamp_d = rom_word[LAMP_W-1:0];

  tl_phase_reg u_phase (
    .clk    (clk),
    .rst    (rst),
    .car_ew (car_ew),
    .ph_nxt (ph_nxt),
    .ph_q   (ph_q)
  );

  tl_lamp_reg #(
    .G_W     (GRP_W),
    .G_N     (N_GRP),
    .RST_PAT (LAMP_RESET)
  ) u_lamps (
    .clk    (clk),
    .rst    (rst),
    .lamp_d (lamp_d),
    .lamp_q (lamp_q)
  );

  assign lights = lamp_q;

  AST_LAMP_LAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> lights == lamps_of($past(ph_q)));                                           // R8

endmodule

// File: tb/test_tl_rom_seq.sv
module test_tl_rom_seq;

  logic       clk = 1'b0;
  logic       rst;
  logic       car_ew;
  logic [5:0] lights;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [5:0] NSG = 6'b100001, NSY = 6'b010001, ALR = 6'b001001,
                         EWG = 6'b001100, EWY = 6'b001010;

  tl_rom_seq i_tl_rom_seq (.clk(clk), .rst(rst), .car_ew(car_ew), .lights(lights));

  always #5 clk = ~clk;

  // Vector: {car_ew before the edge, lights expected after it}; starts in first NS green.
  localparam logic [6:0] VEC [20] = '{
    {1'b1, NSG}, {1'b1, NSG}, {1'b0, NSG}, {1'b1, NSG}, {1'b0, NSY},
    {1'b0, ALR}, {1'b1, EWG}, {1'b1, EWG}, {1'b0, EWG}, {1'b1, EWY},
    {1'b1, ALR}, {1'b1, NSG}, {1'b0, NSG}, {1'b1, NSG}, {1'b1, NSY},
    {1'b1, ALR}, {1'b0, EWG}, {1'b0, EWY}, {1'b0, ALR}, {1'b0, NSG}
  };

  // Reference model, numbered by position in the cycle.
  function automatic logic [5:0] ref_lamps(int s);
    if (s < 3)  return NSG;
    if (s == 3) return NSY;
    if (s == 5) return EWG;
    if (s == 6) return EWY;
    return ALR;
  endfunction

  function automatic int ref_next(int s, bit car);
    if (s < 2)  return s + 1;
    if (s == 2) return car ? 3 : 2;
    if (s == 5) return car ? 5 : 6;
    if (s == 7) return 0;
    return s + 1;
  endfunction

  task automatic chk(string tag, logic [5:0] got, logic [5:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: lights=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic step(bit car);
    car_ew = car;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    car_ew = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: lights=%b expected=%s", lights, "completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [5:0]  prev, prev2;
    int          m;
    int          grn;
    logic [5:0]  exp;

    do_reset();
    chk("R2 reset lamps", lights, NSG);

    // Table walk
    for (int i = 0; i < 20; i++) begin
      step(VEC[i][6]);
      chk($sformatf("R8 vector %0d", i), lights, VEC[i][5:0]);
    end

    // R3: NS green lasts three cycles even with the sensor high throughout
    do_reset();
    grn = 0;
    for (int i = 0; i < 3; i++) begin
      step(1'b1);
      if (lights == NSG) grn++;
    end
    n_run++;
    if (grn != 3) begin
      n_fail++;
      $display("FAIL R3 min green: count=%0d expected=3", grn);
    end
    step(1'b1); chk("R5 NS yellow", lights, NSY);
    step(1'b1); chk("R5 one all-red", lights, ALR);
    step(1'b1); chk("R5 EW green after red", lights, EWG);

    // R6: EW green held five more cycles with the sensor high
    for (int i = 0; i < 5; i++) begin
      step(1'b1); chk($sformatf("R6 hold %0d", i), lights, EWG);
    end
    step(1'b0); chk("R6 last green", lights, EWG);
    step(1'b0); chk("R7 EW yellow", lights, EWY);
    step(1'b0); chk("R7 one all-red", lights, ALR);
    step(1'b0); chk("R7 back to NS", lights, NSG);

    // R4: third green waits with the sensor low
    for (int i = 0; i < 6; i++) begin
      step(1'b0); chk($sformatf("R4 wait %0d", i), lights, NSG);
    end
    step(1'b1); chk("R4 leave edge", lights, NSG);
    step(1'b0); chk("R4 yellow", lights, NSY);
    step(1'b0); chk("R5 red", lights, ALR);

    // R2: reset in the middle of a run (machine is in EW green now)
    rst = 1'b1;
    step(1'b1);
    chk("R2 mid-run reset", lights, NSG);
    rst = 1'b0;

    // Pseudo-random run against the model (R1, R5, R7, R8)
    m = 0;
    lfsr = 16'hACE1;
    prev = NSG;
    prev2 = NSG;
    for (int i = 0; i < 400; i++) begin
      bit car;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      car = lfsr[0] | lfsr[3];
      exp = ref_lamps(m);
      m = ref_next(m, car);
      step(car);
      chk($sformatf("R8 random %0d", i), lights, exp);
      if (prev[4] || prev[1]) chk("R5 R7 red after yellow", lights, ALR);
      if ((prev2[4] || prev2[1]) && prev == ALR) begin
        n_run++;
        if (!(lights[5] || lights[2])) begin
          n_fail++;
          $display("FAIL R5 R7 single red: lights=%b expected=a green", lights);
        end
      end
      n_run++;
      if ($countones(lights[5:3]) != 1 || $countones(lights[2:0]) != 1) begin
        n_fail++;
        $display("FAIL R1 one-hot: lights=%b expected=one lamp per group", lights);
      end
      prev2 = prev;
      prev = lights;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule